// File: doc/BRIEF.md
# Two-Byte Loaded Double-Buffered DAC Code Register

This block is the digital front end of a 14-bit digital-to-analog converter. An 8-bit processor bus fills it in two byte writes. It holds a 6-bit upper holding register, an 8-bit lower holding register and the 14-bit code register that drives the converter. The bus side has an active-low select, an active-low write strobe, a 2-bit offset and an 8-bit data byte. The block sees one action each time the combined select-and-write strobe goes active.

The strobe is asynchronous to the system clock, so the block passes it through a chain of synchroniser flops and acts on the edge where it becomes active. Depending on the offset, a write does one of four things:
- fills one holding register,
- moves both holding registers into the code register together,
- loads all three registers from the same byte.

The last case lets software set zero or full scale with one write. A normal update writes the upper byte, then the lower byte, then a transfer. Because the output only moves on the transfer, several converters can be loaded one after another and then updated together. A one-cycle pulse marks each cycle in which the code register takes a new value.

Top module: `bytewise_dac_front`

## Requirements
- R1: After reset the code output is 0, both holding registers are 0 and the change pulse is low.
- R2: While the select input is high, no register changes, whatever the write strobe, offset and data do.
- R3: While the select input is low and the write strobe stays high, no register changes.
- R4: A write at offset 0 loads the upper holding register with data bits 5..0 and the lower holding register with data bits 7..0. The same write sets the code to {data[5:0], data[7:0]}, so 0x00 gives code 0x0000 and 0xFF gives code 0x3FFF.
- R5: A write at offset 1 loads data bits 5..0 into the upper holding register. Data bits 7..6 are dropped and the code output does not change.
- R6: A write at offset 2 loads data bits 7..0 into the lower holding register, and the code output does not change.
- R7: A write at offset 3 sets the code to {upper, lower}, with the upper register forming code bits 13..8. The data byte has no effect on this write.
- R8: Each active strobe causes exactly one action, however long it stays active. The code changes at the third rising clock edge after select and write are both low (with two synchroniser stages).
- R9: The change pulse is high for exactly one cycle, in the same cycle that the new code first appears. A write that leaves the code value the same produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register offset: 0 direct, 1 upper, 2 lower, 3 transfer |
| data | input | 8 | Bus data byte |
| dac_code | output | 14 | Code register contents driving the converter |
| dac_upd | output | 1 | One-cycle pulse when the code register changes |

## Verification
The bench builds the block with its defaults: an 8-bit bus, a 6-bit upper register and two synchroniser stages. The two-stage chain makes the exact three-edge latency observable cycle by cycle. The 6-bit upper width means a byte with bits 7..6 set shows whether those bits are correctly dropped. The 8+6 split puts the full-scale code at 0x3FFF, which a single all-ones direct write must reach.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   typedef enum logic [1:0] {
      SEL_DIRECT = 2'b00,
      SEL_UPPER  = 2'b01,
      SEL_LOWER  = 2'b10,
      SEL_XFER   = 2'b11
   } dacfe_sel_e;

   function automatic logic sel_loads_upper(dacfe_sel_e s);
      return (s == SEL_DIRECT) || (s == SEL_UPPER);
   endfunction

   function automatic logic sel_loads_lower(dacfe_sel_e s);
      return (s == SEL_DIRECT) || (s == SEL_LOWER);
   endfunction

   function automatic logic sel_loads_code(dacfe_sel_e s);
      return (s == SEL_DIRECT) || (s == SEL_XFER);
   endfunction

endpackage

// File: rtl/dacfe_strobe_sync.sv
module dacfe_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_async,
   output logic fire_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= strobe_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign fire_o = chain_q[STAGES-1] & ~last_q;

   // one action per strobe: never two action cycles back to back (R8)
   assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);

endmodule

// File: rtl/dacfe_hold_regs.sv
module dacfe_hold_regs
   import dacfe_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int HI_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  dacfe_sel_e       sel,
   input  logic [BUS_W-1:0] bus,
   output logic [HI_W-1:0]  hi_o,
   output logic [BUS_W-1:0] lo_o
);

   logic ld_hi, ld_lo;

   assign ld_hi = fire && sel_loads_upper(sel);
   assign ld_lo = fire && sel_loads_lower(sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_o <= '0;
         lo_o <= '0;
      end else begin
         if (ld_hi) hi_o <= bus[HI_W-1:0];
         if (ld_lo) lo_o <= bus;
      end
   end

   // upper register takes the right-justified low bits of the byte (R5)
   assert_upper_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hi |=> hi_o == $past(bus[HI_W-1:0]));

   // lower register takes the whole byte (R6)
   assert_lower_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> lo_o == $past(bus));

   // holding registers stay put without an action (R2, R3)
   assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> ($stable(hi_o) && $stable(lo_o)));

endmodule

// File: rtl/dacfe_code_reg.sv
module dacfe_code_reg #(
   parameter int DAC_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DAC_W-1:0] next_code,
   output logic [DAC_W-1:0] code_o,
   output logic             upd_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         upd_o  <= 1'b0;
      end else begin
         upd_o <= load && (next_code != code_o);
         if (load) code_o <= next_code;
      end
   end

   // pulse marks a real change of value (R9)
   assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> code_o != $past(code_o));

   // no change without the pulse (R9)
   assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> $stable(code_o));

endmodule

// File: rtl/bytewise_dac_front.sv
module bytewise_dac_front
   import dacfe_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int HI_W        = 6,
   parameter int SYNC_STAGES = 2,
   localparam int DAC_W      = BUS_W + HI_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] data,
   output logic [DAC_W-1:0] dac_code,
   output logic             dac_upd
);

   generate
      if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_hi_w
         $error("HI_W must lie between 1 and BUS_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             strobe;
   logic             fire;
   dacfe_sel_e       sel;
   logic [HI_W-1:0]  hi_q;
   logic [BUS_W-1:0] lo_q;
   logic [DAC_W-1:0] next_code;
   logic             load_code;

   assign strobe = ~cs_n & ~wr_n;
   assign sel    = dacfe_sel_e'(addr);

   dacfe_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe_async (strobe),
      .fire_o       (fire)
   );

   dacfe_hold_regs #(.BUS_W(BUS_W), .HI_W(HI_W)) hold_i (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .sel   (sel),
      .bus   (data),
      .hi_o  (hi_q),
      .lo_o  (lo_q)
   );

   assign next_code = (sel == SEL_DIRECT) ? {data[HI_W-1:0], data} : {hi_q, lo_q};
   assign load_code = fire && sel_loads_code(sel);

   dacfe_code_reg #(.DAC_W(DAC_W)) code_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_code),
      .next_code (next_code),
      .code_o    (dac_code),
      .upd_o     (dac_upd)
   );

   // transfer joins both holding registers, bus ignored (R7)
   assert_xfer_join_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel == SEL_XFER) |=> dac_code == {$past(hi_q), $past(lo_q)});

   // direct write replicates the byte into both halves (R4)
   assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel == SEL_DIRECT) |=> dac_code == {$past(data[HI_W-1:0]), $past(data)});

   // byte loads leave the output alone (R5, R6)
   assert_byte_no_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (sel == SEL_UPPER || sel == SEL_LOWER)) |=> $stable(dac_code));

   // no action can start while the bus is deselected for the whole window (R2)
   assert_deselect_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !fire);

endmodule

// File: tb/bytewise_dac_front_tb_top.sv
module bytewise_dac_front_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [1:0]  addr = 2'b00;
   logic [7:0]  data = 8'h00;
   logic [13:0] dac_code;
   logic        dac_upd;

   int n_chk = 0;
   int n_bad = 0;
   int n_pulse = 0;
   bit finished = 1'b0;

   logic [13:0] expq[$];
   logic [5:0]  m_hi = '0;
   logic [7:0]  m_lo = '0;
   logic [13:0] m_code = '0;

   always #10 clk = ~clk;

   bytewise_dac_front dut_i (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .wr_n (wr_n),
      .addr (addr), .data (data), .dac_code (dac_code), .dac_upd (dac_upd)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: every change pulse pops the next expected code
   always @(negedge clk) begin
      if (rst_n && dac_upd) begin
         n_pulse++;
         if (expq.size() == 0) check(1'b0, "R9 unexpected pulse", dac_code, m_code);
         else begin
            logic [13:0] e;
            e = expq.pop_front();
            check(dac_code == e, "R9 pulse code", dac_code, e);
         end
      end
   end

   task automatic model(input logic [1:0] a, input logic [7:0] d);
      logic [13:0] nc;
      nc = m_code;
      case (a)
         2'b00: begin m_hi = d[5:0]; m_lo = d; nc = {d[5:0], d}; end
         2'b01: m_hi = d[5:0];
         2'b10: m_lo = d;
         default: nc = {m_hi, m_lo};
      endcase
      if (nc != m_code) expq.push_back(nc);
      m_code = nc;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input int hold);
      model(a, d);
      @(negedge clk);
      addr = a; data = d; cs_n = 1'b0; wr_n = 1'b0;
      repeat (hold) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dac_code == 14'h0, "R1 reset code", dac_code, 0);
      check(dac_upd == 1'b0, "R1 reset pulse", dac_upd, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 direct loads
      bus_write(2'b00, 8'hFF, 4);
      check(dac_code == 14'h3FFF, "R4 full scale", dac_code, 14'h3FFF);
      bus_write(2'b00, 8'h00, 4);
      check(dac_code == 14'h0000, "R4 zero", dac_code, 0);
      bus_write(2'b00, 8'hA5, 4);
      check(dac_code == 14'h25A5, "R4 replicated byte", dac_code, 14'h25A5);

      // R5 / R6 byte loads do not move the output
      bus_write(2'b01, 8'hFC, 4);
      check(dac_code == 14'h25A5, "R5 output held", dac_code, 14'h25A5);
      bus_write(2'b10, 8'h81, 3);
      check(dac_code == 14'h25A5, "R6 output held", dac_code, 14'h25A5);
      // R7 transfer, bus data ignored
      bus_write(2'b11, 8'h55, 4);
      check(dac_code == 14'h3C81, "R7 transfer with bits 7..6 dropped", dac_code, 14'h3C81);

      // R2 deselected activity
      @(negedge clk);
      cs_n = 1'b1; addr = 2'b00; data = 8'hFF;
      for (int i = 0; i < 6; i++) begin
         wr_n = 1'b0; @(negedge clk); @(negedge clk);
         wr_n = 1'b1; @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check(dac_code == 14'h3C81, "R2 code unchanged", dac_code, 14'h3C81);

      // R3 selected without write
      cs_n = 1'b0; wr_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         addr = 2'(i); data = 8'h11 * 8'(i + 3);
         repeat (2) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      check(dac_code == 14'h3C81, "R3 code unchanged", dac_code, 14'h3C81);

      // holding registers untouched by R2/R3: transfer gives the same value, no pulse (R9)
      begin
         int p0;
         p0 = n_pulse;
         bus_write(2'b11, 8'h00, 4);
         check(dac_code == 14'h3C81, "R2 holding regs intact", dac_code, 14'h3C81);
         check(n_pulse == p0, "R9 no pulse on equal value", n_pulse, p0);
      end

      // R8 latency and single action for a long strobe
      bus_write(2'b01, 8'h12, 4);
      bus_write(2'b10, 8'h34, 4);
      begin
         int p0;
         p0 = n_pulse;
         model(2'b11, 8'hEE);
         @(negedge clk);
         addr = 2'b11; data = 8'hEE; wr_n = 1'b0;
         @(negedge clk);
         cs_n = 1'b0;                 // combined strobe active from here
         @(negedge clk);
         @(negedge clk);
         check(dac_code == 14'h3C81, "R8 unchanged after two edges", dac_code, 14'h3C81);
         @(negedge clk);
         check(dac_code == 14'h1234, "R8 new code at third edge", dac_code, 14'h1234);
         check(dac_upd == 1'b1, "R9 pulse with new code", dac_upd, 1);
         @(negedge clk);
         check(dac_upd == 1'b0, "R9 pulse one cycle", dac_upd, 0);
         repeat (20) @(negedge clk);
         cs_n = 1'b1; wr_n = 1'b1;
         repeat (5) @(negedge clk);
         check(n_pulse == p0 + 1, "R8 one action per long strobe", n_pulse, p0 + 1);
      end

      // R8 repeated direct writes
      bus_write(2'b00, 8'h3C, 8);
      check(dac_code == 14'h3C3C, "R8 direct after long hold", dac_code, 14'h3C3C);

      repeat (4) @(negedge clk);
      check(expq.size() == 0, "R9 all expected changes seen", expq.size(), 0);
      finish_run();
   end

endmodule